// File: doc/BRIEF.md
# Command-driven serial shift engine

This block reads a stream of command bytes from a byte-wide input FIFO port and turns each data-transfer command into a synchronous serial transfer. The transfer runs on four pins: a serial clock, a data output, a data input and a mode-select (TMS) output. A single opcode byte chooses all of the following at once: whether data goes out, whether data comes in, MSB-first or LSB-first order, whether the count is in bytes or in bits, which clock edge launches outgoing data, which edge samples incoming data, and whether the payload drives the TMS pin. One engine therefore serves both SPI-style byte streams and JTAG-style state-machine sequences.

Bytes captured from the data input pin are handed to a byte-wide output FIFO port. A divider input sets the serial clock rate. Opcodes with the top bit set belong to other logic, so this engine reads them and drops them. The engine holds its full state whenever the input side has no byte ready or the output side cannot accept one.

Top module: `serial_cmd_engine`

## Requirements
- R1: An opcode byte with bit 7 set is consumed and discarded. No serial clock edge follows it, and the next byte is taken as a new opcode.
- R2: A byte-counted command (opcode bit 1 clear) is the opcode, then a length low byte, then a length high byte. It moves length+1 bytes. When opcode bit 4 (data out) is set, one payload byte is read from the input port before each byte is shifted.
- R3: Opcode bit 3 set shifts each byte least-significant bit first. Clear shifts most-significant bit first.
- R4: The serial clock idles low, and each bit is a low phase followed by a high phase. Opcode bit 0 set changes the output pins only on falling serial clock edges, with the first bit placed before the first rising edge. Clear changes them only on rising edges.
- R5: Opcode bit 2 set samples the data input on the falling serial clock edge. Clear samples it on the rising edge.
- R6: A bit-counted command (opcode bit 1 set) is the opcode, then one length byte. It moves (length & 7)+1 bits, with at most one payload byte.
- R7: With opcode bit 5 (data in) set, every completed byte or bit group produces one byte on the output port. With bit 4 and bit 6 clear, no payload byte is read and the data output pin holds its previous level.
- R8: In bit mode with data in enabled, the n captured bits are packed into one byte. MSB-first transfers place them in the top n bits, with the first bit in bit 7. LSB-first transfers place them in the bottom n bits, with the first bit in bit 0.
- R9: With opcode bit 6 set, the payload bits drive the TMS pin in the selected order. The data output pin holds payload bit 7 for the whole command.
- R10: Each serial clock phase lasts div_cfg+1 system clock cycles.
- R11: The engine stalls without loss while the input port has no byte ready or a result byte is still waiting on the output port. A waiting result keeps its value until it is accepted.
- R12: After reset the serial clock, data output, TMS and output valid are all low, and the engine is ready to accept an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | DIV_W | Serial clock phase length minus one, in system clocks |
| in_data | input | 8 | Command/payload byte from the input FIFO |
| in_valid | input | 1 | Input FIFO holds a byte |
| in_ready | output | 1 | Engine takes in_data on this cycle when in_valid is high |
| out_data | output | 8 | Captured result byte |
| out_valid | output | 1 | out_data is waiting to be accepted |
| out_ready | input | 1 | Output FIFO accepts out_data |
| ser_clk | output | 1 | Serial clock |
| ser_dout | output | 1 | Serial data output |
| ser_tms | output | 1 | Mode-select output driven in TMS mode |
| ser_din | input | 1 | Serial data input |

## Verification
Two situations are the hardest to reach. The first is a data-in transfer in which the first result byte sits unaccepted while the engine has already shifted the second byte and must wait before writing it out. The stimulus holds out_ready low across a two-byte loopback command, checks the serial edge count and the waiting byte, and only then releases the output. The second is a command left without its payload after the length bytes. The bench stops feeding there, confirms that no serial edge appears, and then supplies a payload whose top bit is set, to show that it is treated as data and not as an opcode. Each edge-selection case runs with the data input looped back to the data output, so the captured byte proves the launch and sample edges relative to each other.

// File: rtl/sce_pkg.sv
package sce_pkg;
  // opcode field layout; positions are fixed by the command stream
  typedef struct packed {
    logic special;   // bit 7
    logic tms;       // bit 6
    logic din_en;    // bit 5
    logic dout_en;   // bit 4
    logic lsb;       // bit 3
    logic icn;       // bit 2 sample on falling edge
    logic bits;      // bit 1 bit-counted length
    logic ocn;       // bit 0 launch on falling edge
  } sce_op_t;

  typedef enum logic [2:0] {
    ST_OPC, ST_LEN0, ST_LEN1, ST_FETCH, ST_GO, ST_SHIFT, ST_PUSH, ST_NEXT
  } sce_state_t;
endpackage

// File: rtl/sce_clkdiv.sv
module sce_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == div);

  // R10: two ticks never come back to back unless the phase is one cycle
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/sce_shifter.sv
module sce_shifter #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  data,
  input  logic [CW-1:0] nbits,
  input  logic          lsb,
  input  logic          ocn,
  input  logic          icn,
  input  logic          oe,
  input  logic          tms_mode,
  input  logic          tick,
  input  logic          din,
  output logic          busy,
  output logic          done,
  output logic          sclk,
  output logic          dout,
  output logic          tms,
  output logic [W-1:0]  packed_out
);
  logic [W-1:0]  sreg, cap;
  logic [CW-1:0] cnt, nb;
  logic          phase, lsb_r, ocn_r, icn_r, oe_r, tms_r;
  logic          nxt;
  logic [W-1:0]  sreg_sh, cap_nx;
  logic [CW-1:0] pad;

  assign nxt     = lsb_r ? sreg[0] : sreg[W-1];
  assign sreg_sh = lsb_r ? (sreg >> 1) : (sreg << 1);
  assign cap_nx  = lsb_r ? {din, cap[W-1:1]} : {cap[W-2:0], din};
  assign pad     = CW'(W) - nb;
  assign packed_out = lsb_r ? (cap >> pad) : (cap << pad);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy <= 1'b0; sclk <= 1'b0; dout <= 1'b0; tms <= 1'b0; phase <= 1'b0;
      sreg <= '0; cap <= '0; cnt <= '0; nb <= '0;
      lsb_r <= 1'b0; ocn_r <= 1'b0; icn_r <= 1'b0; oe_r <= 1'b0; tms_r <= 1'b0;
    end else if (start && !busy) begin
      busy <= 1'b1; phase <= 1'b0; cap <= '0; cnt <= nbits; nb <= nbits;
      lsb_r <= lsb; ocn_r <= ocn; icn_r <= icn; oe_r <= oe; tms_r <= tms_mode;
      if (tms_mode) dout <= data[W-1];
      if (ocn) begin
        if (tms_mode) tms <= lsb ? data[0] : data[W-1];
        else if (oe) dout <= lsb ? data[0] : data[W-1];
        sreg <= lsb ? (data >> 1) : (data << 1);
      end else begin
        sreg <= data;
      end
    end else if (busy && tick) begin
      if (!phase) begin
        sclk <= 1'b1; phase <= 1'b1;
        if (!ocn_r) begin
          if (tms_r) tms <= nxt;
          else if (oe_r) dout <= nxt;
          sreg <= sreg_sh;
        end
        if (!icn_r) cap <= cap_nx;
      end else begin
        sclk <= 1'b0; phase <= 1'b0;
        if (icn_r) cap <= cap_nx;
        if (cnt == CW'(1)) begin
          busy <= 1'b0; done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
          if (ocn_r) begin
            if (tms_r) tms <= nxt;
            else if (oe_r) dout <= nxt;
            sreg <= sreg_sh;
          end
        end
      end
    end
  end

  // R10: the serial clock only moves one cycle after a divider tick
  p_clk_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sclk));
  // R4: falling-edge launch leaves the pins untouched at the rising edge
  p_launch_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && tick && !phase && ocn_r) |=> ($stable(dout) && $stable(tms)));
  // R4: every transfer ends with the serial clock back low
  p_idle_low_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !sclk);
endmodule

// File: rtl/serial_cmd_engine.sv
module serial_cmd_engine
  import sce_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             ser_clk,
  output logic             ser_dout,
  output logic             ser_tms,
  input  logic             ser_din
);
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  sce_state_t    state;
  sce_op_t       op;
  logic [15:0]   left;
  logic [2:0]    bitlen;
  logic [W-1:0]  pay;
  logic          take, need_pay, sh_start, sh_busy, sh_done, tick;
  logic [CW-1:0] sh_nbits;
  logic [W-1:0]  sh_packed;

  assign in_ready = (state == ST_OPC) || (state == ST_LEN0) ||
                    (state == ST_LEN1) || (state == ST_FETCH);
  assign take     = in_valid && in_ready;
  assign need_pay = op.dout_en || op.tms;
  assign sh_start = (state == ST_GO);
  assign sh_nbits = op.bits ? (CW'(bitlen) + CW'(1)) : CW'(W);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OPC; op <= '0; left <= '0; bitlen <= '0; pay <= '0;
      out_data <= '0; out_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_OPC: if (take && !in_data[7]) begin
          op <= sce_op_t'(in_data);
          state <= ST_LEN0;
        end
        ST_LEN0: if (take) begin
          left[7:0] <= in_data;
          bitlen <= in_data[2:0];
          if (op.bits) begin
            left <= '0;
            if (need_pay) state <= ST_FETCH;
            else begin pay <= '0; state <= ST_GO; end
          end else begin
            state <= ST_LEN1;
          end
        end
        ST_LEN1: if (take) begin
          left[15:8] <= in_data;
          if (need_pay) state <= ST_FETCH;
          else begin pay <= '0; state <= ST_GO; end
        end
        ST_FETCH: if (take) begin
          pay <= in_data;
          state <= ST_GO;
        end
        ST_GO: state <= ST_SHIFT;
        ST_SHIFT: if (sh_done) state <= op.din_en ? ST_PUSH : ST_NEXT;
        ST_PUSH: if (!out_valid) begin
          out_data <= sh_packed;
          out_valid <= 1'b1;
          state <= ST_NEXT;
        end
        ST_NEXT: begin
          if (left == '0) state <= ST_OPC;
          else begin
            left <= left - 1'b1;
            state <= need_pay ? ST_FETCH : ST_GO;
          end
        end
        default: state <= ST_OPC;
      endcase
    end
  end

  sce_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(sh_busy), .div(div_cfg), .tick(tick)
  );

  sce_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .data(pay), .nbits(sh_nbits),
    .lsb(op.lsb), .ocn(op.ocn), .icn(op.icn), .oe(op.dout_en),
    .tms_mode(op.tms), .tick(tick), .din(ser_din), .busy(sh_busy),
    .done(sh_done), .sclk(ser_clk), .dout(ser_dout), .tms(ser_tms),
    .packed_out(sh_packed)
  );

  // R11: a waiting result is held unchanged until accepted
  p_out_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R1: a special opcode leaves the engine waiting for the next opcode
  p_special_skip_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPC && take && in_data[7]) |=> (state == ST_OPC));
  // R1: a special opcode is never latched as the active command
  p_no_special_latched_r1: assert property (@(posedge clk) disable iff (rst)
    (state != ST_OPC) |-> !op.special);
endmodule

// File: tb/sim_serial_cmd_engine.sv
module sim_serial_cmd_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [15:0] div_cfg;
  logic [7:0]  in_data;
  logic        in_valid, in_ready;
  logic [7:0]  out_data;
  logic        out_valid, out_ready;
  logic        ser_clk, ser_dout, ser_tms, ser_din;
  logic        loop, din_c, fall_launch;

  assign ser_din = loop ? ser_dout : din_c;

  serial_cmd_engine #(.DIV_W(16)) u0 (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .ser_clk(ser_clk),
    .ser_dout(ser_dout), .ser_tms(ser_tms), .ser_din(ser_din)
  );

  int checks = 0, errors = 0;
  int nr = 0, ngot = 0, viol = 0, cyc = 0, last_rise = 0, rise_gap = 0;
  logic rec_d [0:63];
  logic rec_t [0:63];
  logic [7:0] got [0:15];
  logic p_clk = 1'b0, p_dout = 1'b0;

  // edge monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (ser_clk && !p_clk) begin
        if (nr < 64) begin rec_d[nr] = ser_dout; rec_t[nr] = ser_tms; end
        nr++;
        if (fall_launch && ser_dout !== p_dout) viol++;
        rise_gap = cyc - last_rise;
        last_rise = cyc;
      end
      if (!ser_clk && p_clk && !fall_launch && ser_dout !== p_dout) viol++;
      if (out_valid && out_ready && ngot < 16) begin got[ngot] = out_data; ngot++; end
    end
    p_clk = ser_clk;
    p_dout = ser_dout;
    cyc++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_data = b; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_rec();
    nr = 0; ngot = 0; viol = 0;
  endtask

  task automatic check_bits(input string tag, input logic [7:0] v, input bit lsbf,
                            input int n, input int base, input bit use_tms);
    for (int i = 0; i < n; i++) begin
      logic e;
      e = lsbf ? v[i] : v[7 - i];
      check(tag, use_tms ? int'(rec_t[base + i]) : int'(rec_d[base + i]), int'(e));
    end
  endtask

  task automatic t_reset();
    check("R12 sclk", ser_clk, 0);
    check("R12 dout", ser_dout, 0);
    check("R12 tms", ser_tms, 0);
    check("R12 out_valid", out_valid, 0);
    check("R12 in_ready", in_ready, 1);
  endtask

  task automatic t_byte_msb_fall();
    clear_rec(); fall_launch = 1; loop = 0;
    put(8'h11); put(8'h01); put(8'h00); put(8'hA5); put(8'h3C);
    settle(120);
    check("R2 bit count", nr, 16);
    check_bits("R3 msb byte0", 8'hA5, 0, 8, 0, 0);
    check_bits("R3 msb byte1", 8'h3C, 0, 8, 8, 0);
    check("R4 falling launch", viol, 0);
    check("R7 no result", ngot, 0);
  endtask

  task automatic t_byte_lsb_rise();
    clear_rec(); fall_launch = 0;
    put(8'h18); put(8'h00); put(8'h00); put(8'h96);
    settle(60);
    check("R2 one byte", nr, 8);
    check_bits("R3 lsb", 8'h96, 1, 8, 0, 0);
    check("R4 rising launch", viol, 0);
  endtask

  task automatic t_bits_lsb_loop();
    clear_rec(); fall_launch = 1; loop = 1;
    put(8'h3B); put(8'h04); put(8'h15);
    settle(60);
    check("R6 five bits", nr, 5);
    check_bits("R6 bits out", 8'h15, 1, 5, 0, 0);
    check("R5 rising sample count", ngot, 1);
    check("R8 lsb packed", got[0], 8'h15);
  endtask

  task automatic t_bits_msb_loop();
    clear_rec(); fall_launch = 0; loop = 1;
    put(8'h36); put(8'h02); put(8'hA0);
    settle(40);
    check("R6 three bits", nr, 3);
    check("R5 falling sample count", ngot, 1);
    check("R8 msb packed", got[0], 8'hA0);
    check("R4 rising launch bits", viol, 0);
  endtask

  task automatic t_in_only();
    logic held;
    clear_rec(); loop = 0; din_c = 1;
    held = ser_dout;
    put(8'h20); put(8'h00); put(8'h00);
    put(8'h20); put(8'h00); put(8'h00);
    settle(120);
    check("R7 two results", ngot, 2);
    check("R7 result0", got[0], 8'hFF);
    check("R7 result1", got[1], 8'hFF);
    check("R7 dout held", ser_dout, held);
    check("R7 edges", nr, 16);
    din_c = 0;
  endtask

  task automatic t_tms();
    clear_rec(); fall_launch = 1; loop = 0;
    put(8'h4B); put(8'h06); put(8'h83);
    settle(60);
    check("R9 seven bits", nr, 7);
    check_bits("R9 tms seq", 8'h83, 1, 7, 0, 1);
    for (int i = 0; i < 7; i++) check("R9 dout bit7", rec_d[i], 1);
  endtask

  task automatic t_special();
    clear_rec(); fall_launch = 1;
    put(8'h85); put(8'h9E);
    settle(20);
    check("R1 no edges", nr, 0);
    check("R1 ready", in_ready, 1);
    put(8'h19); put(8'h00); put(8'h00); put(8'h01);
    settle(60);
    check("R1 next cmd edges", nr, 8);
    check_bits("R1 next cmd data", 8'h01, 1, 8, 0, 0);
  endtask

  task automatic t_out_stall();
    clear_rec(); fall_launch = 1; loop = 1; out_ready = 0;
    put(8'h31); put(8'h01); put(8'h00); put(8'h5A); put(8'hC3);
    settle(300);
    check("R11 edges while full", nr, 16);
    check("R11 valid held", out_valid, 1);
    check("R11 data held", out_data, 8'h5A);
    out_ready = 1;
    settle(20);
    check("R11 count", ngot, 2);
    check("R11 first", got[0], 8'h5A);
    check("R11 second", got[1], 8'hC3);
    loop = 0;
  endtask

  task automatic t_in_stall();
    clear_rec(); fall_launch = 0;
    put(8'h10); put(8'h00); put(8'h00);
    settle(100);
    check("R11 no edges while empty", nr, 0);
    check("R11 waiting payload", in_ready, 1);
    put(8'h81);
    settle(60);
    check("R2 payload edges", nr, 8);
    check_bits("R2 payload as data", 8'h81, 0, 8, 0, 0);
  endtask

  task automatic t_divider();
    clear_rec(); div_cfg = 16'd3; fall_launch = 0;
    put(8'h10); put(8'h00); put(8'h00); put(8'h00);
    settle(120);
    check("R10 edges", nr, 8);
    check("R10 period", rise_gap, 8);
    div_cfg = 16'd1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; div_cfg = 16'd1; in_data = '0; in_valid = 0; out_ready = 1;
    loop = 0; din_c = 0; fall_launch = 1;
    settle(5);
    rst = 0;
    settle(2);
    t_reset();
    t_byte_msb_fall();
    t_byte_lsb_rise();
    t_bits_lsb_loop();
    t_bits_msb_loop();
    t_in_only();
    t_tms();
    t_special();
    t_out_stall();
    t_in_stall();
    t_divider();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule